// File: doc/BRIEF.md
# Modem Status Register with Change Flags

This block keeps the modem status byte of a 16550-style serial port. It samples four incoming handshake lines (clear-to-send, data-set-ready, ring indicator and carrier detect) through a two-flop synchronizer. It holds their current levels in the upper half of the byte and a sticky change flag for each line in the lower half. The change flags collect every transition until a processor read of the byte clears them. A single "any change" output goes to the interrupt logic of the port.

The modem control byte comes in as a plain input from the register that owns it. When its loopback bit is set, a read returns the four control outputs crossed onto the status positions instead of the real lines, and the lower half reads as zero. In this mode a read leaves the change flags untouched, and the external lines are still tracked underneath.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the read value is 0xB0: carrier detect, data-set-ready and clear-to-send read as 1, ring indicator as 0, all four change flags as 0, and `any_chg` is 0.
- R2: Outside loopback, read bits 7..4 are carrier detect, ring indicator, data-set-ready and clear-to-send. A level change on an input line appears there on the third rising clock edge after it is applied.
- R3: A transition in either direction on clear-to-send, data-set-ready or carrier detect sets change bit 0, 1 or 3 when the new level reaches the upper nibble. A change bit stays set until it is cleared by a read.
- R4: Change bit 2 is set only when the ring indicator level goes from 1 to 0. A 0-to-1 transition of the ring indicator leaves it unchanged.
- R5: A read strobe outside loopback clears all four change bits on the next clock edge. A transition that reaches the upper nibble on that same edge still sets its bit.
- R6: `any_chg` is 1 exactly when at least one of the four change bits is set.
- R7: When control bit 4 is 1, the read value is {ctl[3], ctl[2], ctl[0], ctl[1], 4'b0000}. Control bit 3 shows as carrier detect, bit 2 as ring indicator, bit 0 as data-set-ready and bit 1 as clear-to-send.
- R8: A read strobe while control bit 4 is 1 does not clear the change bits. They remain visible through `any_chg`, and they read back after loopback is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| ctl_i | input | 5 | Modem control byte bits 4..0 (bit 4 loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS, bit 0 DTR) |
| rd_stb | input | 1 | One-cycle read strobe for the status byte |
| rd_data | output | 8 | Status byte as seen by a read |
| any_chg | output | 1 | Any change flag set, to the interrupt logic |

## Verification
The assertions take the four lines to be sampled only through the synchronizer. They also take the read strobe to be a single-cycle pulse that the owning bus logic raises once per access, so clearing is judged edge by edge. The stimulus keeps the lines at their reset levels while reset is held and changes them only between clock edges. It holds each new level long enough to cross all register stages, and it places reads both on quiet cycles and on the exact edge where a transition lands.

// File: rtl/msr_pkg.sv
// Shared constants for the modem status register.
// Assumes the fixed nibble layout {dcd, ri, dsr, cts} for levels and flags.
package msr_pkg;
    localparam int NLINES    = 4;
    localparam int IDX_CTS   = 0;
    localparam int IDX_DSR   = 1;
    localparam int IDX_RI    = 2;
    localparam int IDX_DCD   = 3;
    localparam int CTL_W     = 5;
    localparam int CTL_LOOP  = 4;
    localparam int CTL_OUT2  = 3;
    localparam int CTL_OUT1  = 2;
    localparam int CTL_RTS   = 1;
    localparam int CTL_DTR   = 0;
    localparam logic [NLINES-1:0] LINE_RST = 4'b1011;
endpackage

// File: rtl/msr_line_sync.sv
// Multi-stage synchronizer for asynchronous handshake lines.
// Assumes STAGES >= 1. Each bit resets to its RST_VAL bit so that no change
// is seen when reset is released.
module msr_line_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw lines
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Later stages shift the sample along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= RST_VAL;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/msr_delta_track.sv
// Holds the registered line levels and the sticky change flags.
// Assumes smp is already synchronized and clr is a one-cycle pulse.
module msr_delta_track
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] smp,
    input  logic              clr,
    output logic [NLINES-1:0] lvl,
    output logic [NLINES-1:0] chg
);
    logic [NLINES-1:0] diff;

    // Transitions per line, the ring line counting only its falling edge
    always_comb begin
        diff          = lvl ^ smp;
        diff[IDX_RI]  = lvl[IDX_RI] & ~smp[IDX_RI];
    end

    // Update the levels and accumulate the flags, clearing on a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= LINE_RST;
            chg <= '0;
        end else begin
            lvl <= smp;
            chg <= (clr ? '0 : chg) | diff;
        end
    end

    // R4
    ring_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg[IDX_RI]) |-> ($past(lvl[IDX_RI]) && !lvl[IDX_RI]));

    // R3
    cts_flag_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[IDX_CTS] != smp[IDX_CTS]) |=> chg[IDX_CTS]);

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((chg & $past(chg)) == $past(chg)));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (lvl == smp)) |=> (chg == '0));
endmodule

// File: rtl/msr_read_view.sv
// Forms the byte returned to a read: live status or the loopback cross-map.
// Assumes ctl carries the low five bits of the modem control byte.
module msr_read_view
    import msr_pkg::*;
(
    input  logic [NLINES-1:0] lvl,
    input  logic [NLINES-1:0] chg,
    input  logic [CTL_W-1:0]  ctl,
    output logic [2*NLINES-1:0] dout
);
    logic [NLINES-1:0] loop_lvl;

    // Cross the control outputs onto the status positions
    always_comb begin
        loop_lvl          = '0;
        loop_lvl[IDX_DCD] = ctl[CTL_OUT2];
        loop_lvl[IDX_RI]  = ctl[CTL_OUT1];
        loop_lvl[IDX_DSR] = ctl[CTL_DTR];
        loop_lvl[IDX_CTS] = ctl[CTL_RTS];
    end

    // Choose the read byte by the loopback bit
    always_comb begin
        if (ctl[CTL_LOOP]) dout = {loop_lvl, {NLINES{1'b0}}};
        else               dout = {lvl, chg};
    end
endmodule

// File: rtl/modem_status_reg.sv
// Modem status register: synchronizes four handshake lines, keeps sticky
// change flags, offers a loopback read view and an any-change output.
// Assumes rd_stb pulses once per read access.
module modem_status_reg
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_i,
    input  logic             dsr_i,
    input  logic             ri_i,
    input  logic             dcd_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic             rd_stb,
    output logic [7:0]       rd_data,
    output logic             any_chg
);
    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] smp;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] chg;
    logic              clr;

    assign raw = {dcd_i, ri_i, dsr_i, cts_i};
    assign clr = rd_stb & ~ctl_i[CTL_LOOP];

    msr_line_sync #(
        .WIDTH   (NLINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (smp)
    );

    msr_delta_track u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .clr   (clr),
        .lvl   (lvl),
        .chg   (chg)
    );

    msr_read_view u_view (
        .lvl  (lvl),
        .chg  (chg),
        .ctl  (ctl_i),
        .dout (rd_data)
    );

    assign any_chg = |chg;
endmodule

// File: tb/modem_status_reg_bench.sv
`timescale 1ns/1ps
module modem_status_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] lines = 4'b1011;
    logic [4:0] ctl = 5'h08;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       any_chg;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state: two-deep delay line, levels, flags
    bit [3:0] m_d0 = 4'b1011, m_d1 = 4'b1011, m_lv = 4'b1011, m_fl = 4'b0000;

    always #10 clk = ~clk;

    modem_status_reg u_modem_status_reg (
        .clk(clk), .rst_n(rst_n),
        .cts_i(lines[0]), .dsr_i(lines[1]), .ri_i(lines[2]), .dcd_i(lines[3]),
        .ctl_i(ctl), .rd_stb(rd), .rd_data(rd_data), .any_chg(any_chg)
    );

    function automatic bit [7:0] expect_byte();
        if (ctl[4]) return {ctl[3], ctl[2], ctl[0], ctl[1], 4'b0000};
        return {m_lv, m_fl};
    endfunction

    task automatic compare(input string tag);
        bit [7:0] eb;
        eb = expect_byte();
        checks++;
        if (rd_data !== eb) begin
            errors++;
            $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, eb);
        end
        checks++;
        if (any_chg !== (m_fl != 0)) begin
            errors++;
            $display("FAIL R6 any_chg actual=%0b expected=%0b", any_chg, (m_fl != 0));
        end
    endtask

    // check at the falling edge, apply inputs, advance model past the rising edge
    task automatic step(input bit [3:0] ln, input bit [4:0] c, input bit r, input string tag);
        bit [3:0] nl, diff;
        @(negedge clk);
        compare(tag);
        lines = ln; ctl = c; rd = r;
        @(posedge clk);
        #1;
        nl = m_d1;
        diff = m_lv ^ nl;
        diff[2] = m_lv[2] & ~nl[2];
        m_fl = ((rd && !ctl[4]) ? 4'b0000 : m_fl) | diff;
        m_lv = nl;
        m_d1 = m_d0;
        m_d0 = lines;
    endtask

    task automatic hold(input bit [3:0] ln, input bit [4:0] c, input int n, input string tag);
        for (int i = 0; i < n; i++) step(ln, c, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        hold(4'b1011, 5'h08, 3, "R1");              // reset value 0xB0
        hold(4'b1010, 5'h08, 4, "R2");              // CTS drops, latency and layout
        step(4'b1010, 5'h08, 1'b1, "R5");           // read clears
        hold(4'b1010, 5'h08, 2, "R5");
        hold(4'b1110, 5'h08, 4, "R4");              // RI rises: no flag
        hold(4'b1010, 5'h08, 4, "R4");              // RI falls: flag
        step(4'b1010, 5'h08, 1'b1, "R5");
        hold(4'b0000, 5'h08, 4, "R3");              // DCD and DSR drop
        hold(4'b1111, 5'h08, 4, "R3");              // all rise, flags stay
        step(4'b1111, 5'h08, 1'b1, "R5");
        hold(4'b0101, 5'h08, 2, "R5");              // change lands with a read
        step(4'b0101, 5'h08, 1'b1, "R5");
        hold(4'b0101, 5'h08, 3, "R5");
        step(4'b0101, 5'h08, 1'b1, "R5");
        hold(4'b0101, 5'h08, 2, "R5");
        hold(4'b1011, 5'h11, 4, "R7");              // loopback views, lines change under it
        step(4'b1011, 5'h12, 1'b1, "R8");
        step(4'b1011, 5'h14, 1'b1, "R8");
        step(4'b1011, 5'h18, 1'b1, "R7");
        step(4'b1011, 5'h1F, 1'b1, "R7");
        step(4'b1011, 5'h10, 1'b1, "R7");
        hold(4'b1011, 5'h08, 2, "R8");              // flags survive loopback reads
        step(4'b1011, 5'h08, 1'b1, "R5");
        hold(4'b1011, 5'h08, 3, "R5");
        @(negedge clk);
        compare("R5");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule